// File: doc/BRIEF.md
# Paged BCD Calendar Clock with Alarm

This block is a real-time clock peripheral. Its count advances from a one-pulse-per-second input, and it keeps seconds, minutes, hours, day of week, day of month, month and a four-digit year. Each value is split into 4-bit BCD digits. Every digit has its own register in a 16-entry, 4-bit-wide register space. Two page bits choose which set of registers that space shows. Page 0 holds the running time. Page 1 holds the alarm digits and the alarm control. Page 2 holds the timer control. The last index is a control register that is visible on every page.

A small sequencer takes each accepted tick through two busy cycles. In the first, the carry ripples through the digit chain. In the second, the updated time is compared against the alarm digits. Software reads the time only while busy is clear. Before it writes new time digits, software sets the stop bit. An alarm match sets a sticky flag, and the interrupt output is that flag gated by an enable bit.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00 with day of week 0. Control reads 0 (page 0, running, not busy). Alarm enable and alarm flag are 0, and `irq` is low.
- R2: On page 0, index 0..14 hold, in order: seconds ones, seconds tens, minutes ones, minutes tens, hours ones, hours tens, day of week, day ones, day tens, month ones, month tens, year ones, tens, hundreds and thousands. Each reads back what was written.
- R3: Index 15 is control on every page. Bit 0 is busy and is read-only. Bit 1 is stop. Bits 3:2 are the page number.
- R4: A tick sampled high while running and idle makes busy read 1 for exactly the two following clock cycles. After that the time has advanced by one second.
- R5: Seconds wrap from 59 to 00 and minutes wrap from 59 to 00, each carrying into the next field. Hours wrap from 23 to 00 and carry into the day.
- R6: Day of week counts 0..6 and wraps to 0 each time the day advances.
- R7: Day of month wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11, 31 for the others, and for February 29 when the year is divisible by 4, otherwise 28. Month wraps from 12 to 1 and increments the four-digit year, which wraps from 9999 to 0000.
- R8: While stop is set, the time does not change. Ticks that arrive while stopped are dropped, and they are not counted after stop is cleared.
- R9: On page 1, index 0..8 hold alarm digits in the same order as R2. Bit 3 of indices 1, 3, 5, 6 and 8 is an ignore bit that makes that digit always match. Reads return all 4 bits.
- R10: On page 1, index 14 is alarm control: bit 0 is enable and bit 1 is flag. The flag sets at the end of the busy period when every non-ignored alarm digit equals its time digit. Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 leaves it unchanged.
- R11: `irq` is high exactly when both the alarm flag and the alarm enable are set.
- R12: On page 2, index 14 bit 0 is a read/write timer enable, and its other bits read 0. Every other index outside R2, R3, R9 and R10, including all of page 3, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register index within the selected page |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The counting chain is tested in two ways. A continuous run of consecutive ticks crosses a minute, an hour, a day, a month and a year boundary. A sweep then loads the last day of every month, for both a leap year and a common year, plus 28 February and 9999-12-31. After every tick the bench compares all fifteen digits against an arithmetic calendar model, so an error in the month-length table can be told apart from an error in the carry into month or year. The alarm is tested three ways: with wildcard tens digits, with a non-wildcard digit that blocks the match, and with that same digit switched to a wildcard. This separates the ignore-bit logic from the plain digit compare. The stop, page and unmapped-index cases are read back through the register port.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int NIB_W        = 4;
    localparam int IDX_W        = 4;
    localparam int N_TIME_DIG   = 15;
    localparam int N_ALARM_DIG  = 9;
    localparam int IDX_AUX      = 14;
    localparam int IDX_CTRL     = 15;
    // digits whose bit 3 is an alarm wildcard: 1,3,5,6,8
    localparam logic [N_ALARM_DIG-1:0] WILD_MASK = 9'b1_0110_1010;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_COMPARE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stopped,
    output logic advance,
    output logic compare,
    output logic busy
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        compare = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !stopped) state_d = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                busy    = 1'b1;
                advance = 1'b1;
                state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                busy    = 1'b1;
                compare = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_cal_pkg::*;
#(
    parameter logic [15:0] RESET_YEAR_BCD = 16'h2000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                advance,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [NIB_W-1:0]                    wr_data,
    output logic [N_TIME_DIG-1:0][NIB_W-1:0]    digits
);
    logic [N_TIME_DIG-1:0][NIB_W-1:0] nxt;
    logic [6:0] mday_bin, mon_bin, yr_lo_bin, last_day;
    logic       leap;
    logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        mday_bin  = {3'b0, digits[8]}  * 7'd10 + {3'b0, digits[7]};
        mon_bin   = {3'b0, digits[10]} * 7'd10 + {3'b0, digits[9]};
        yr_lo_bin = {3'b0, digits[12]} * 7'd10 + {3'b0, digits[11]};
        leap      = (yr_lo_bin[1:0] == 2'b00);
        case (mon_bin)
            7'd2:                         last_day = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:      last_day = 7'd30;
            default:                      last_day = 7'd31;
        endcase
    end

    always_comb begin
        nxt   = digits;
        c_sec = 1'b0;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        // seconds
        if (digits[0] >= 4'd9) begin
            nxt[0] = 4'd0;
            if (digits[1] >= 4'd5) begin nxt[1] = 4'd0; c_sec = 1'b1; end
            else nxt[1] = digits[1] + 4'd1;
        end else nxt[0] = digits[0] + 4'd1;
        // minutes
        if (c_sec) begin
            if (digits[2] >= 4'd9) begin
                nxt[2] = 4'd0;
                if (digits[3] >= 4'd5) begin nxt[3] = 4'd0; c_min = 1'b1; end
                else nxt[3] = digits[3] + 4'd1;
            end else nxt[2] = digits[2] + 4'd1;
        end
        // hours
        if (c_min) begin
            if (digits[5] >= 4'd2 && digits[4] >= 4'd3) begin
                nxt[5] = 4'd0; nxt[4] = 4'd0; c_hr = 1'b1;
            end else if (digits[4] >= 4'd9) begin
                nxt[4] = 4'd0; nxt[5] = digits[5] + 4'd1;
            end else nxt[4] = digits[4] + 4'd1;
        end
        // day of week and day of month
        if (c_hr) begin
            nxt[6] = (digits[6][2:0] >= 3'd6) ? 4'd0 : digits[6] + 4'd1;
            if (mday_bin >= last_day) begin
                nxt[8] = 4'd0; nxt[7] = 4'd1; c_day = 1'b1;
            end else if (digits[7] >= 4'd9) begin
                nxt[7] = 4'd0; nxt[8] = digits[8] + 4'd1;
            end else nxt[7] = digits[7] + 4'd1;
        end
        // month
        if (c_day) begin
            if (mon_bin >= 7'd12) begin
                nxt[10] = 4'd0; nxt[9] = 4'd1; c_mon = 1'b1;
            end else if (digits[9] >= 4'd9) begin
                nxt[9] = 4'd0; nxt[10] = 4'd1;
            end else nxt[9] = digits[9] + 4'd1;
        end
        // four year digits
        c_yr = c_mon;
        for (int i = 11; i < N_TIME_DIG; i++) begin
            if (c_yr) begin
                if (digits[i] >= 4'd9) nxt[i] = 4'd0;
                else begin
                    nxt[i] = digits[i] + 4'd1;
                    c_yr   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits        <= '0;
            digits[7]     <= 4'd1;
            digits[9]     <= 4'd1;
            digits[14:11] <= RESET_YEAR_BCD;
        end else if (wr_en && (wr_idx < IDX_W'(N_TIME_DIG))) begin
            digits[wr_idx] <= wr_data;
        end else if (advance) begin
            digits <= nxt;
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_cal_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dig_wr,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [NIB_W-1:0]                    wr_data,
    input  logic                                ctl_wr,
    input  logic                                compare,
    input  logic [N_TIME_DIG-1:0][NIB_W-1:0]    time_digits,
    output logic [N_ALARM_DIG-1:0][NIB_W-1:0]   alarm_digits,
    output logic                                alarm_en,
    output logic                                alarm_flag
);
    logic [N_ALARM_DIG-1:0] hit;

    for (genvar g = 0; g < N_ALARM_DIG; g++) begin : g_cmp
        if (WILD_MASK[g]) begin : g_wild
            assign hit[g] = alarm_digits[g][3] ||
                            (alarm_digits[g][2:0] == time_digits[g][2:0]);
        end else begin : g_exact
            assign hit[g] = (alarm_digits[g] == time_digits[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_digits <= '0;
        end else if (dig_wr && (wr_idx < IDX_W'(N_ALARM_DIG))) begin
            alarm_digits[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_en   <= 1'b0;
            alarm_flag <= 1'b0;
        end else begin
            if (ctl_wr) alarm_en <= wr_data[0];
            if (compare && (&hit))            alarm_flag <= 1'b1;
            else if (ctl_wr && !wr_data[1])   alarm_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
    import rtc_cal_pkg::*;
#(
    parameter logic [15:0] RESET_YEAR_BCD = 16'h2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    output logic       irq
);
    logic [1:0] bank_q;
    logic       stop_q;
    logic       timer_en_q;
    logic       advance, compare, busy;
    logic       alarm_en, alarm_flag;
    logic       is_ctrl, is_aux;
    logic       wr_time, wr_alarm, wr_actl, wr_tctl;
    logic [N_TIME_DIG-1:0][NIB_W-1:0]  time_digits;
    logic [N_ALARM_DIG-1:0][NIB_W-1:0] alarm_digits;

    assign is_ctrl  = (bus_addr == IDX_W'(IDX_CTRL));
    assign is_aux   = (bus_addr == IDX_W'(IDX_AUX));
    assign wr_time  = bus_we && !is_ctrl && (bank_q == 2'd0);
    assign wr_alarm = bus_we && (bank_q == 2'd1) && (bus_addr < IDX_W'(N_ALARM_DIG));
    assign wr_actl  = bus_we && (bank_q == 2'd1) && is_aux;
    assign wr_tctl  = bus_we && (bank_q == 2'd2) && is_aux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= 2'd0;
            stop_q     <= 1'b0;
            timer_en_q <= 1'b0;
        end else begin
            if (bus_we && is_ctrl) begin
                bank_q <= bus_wdata[3:2];
                stop_q <= bus_wdata[1];
            end
            if (wr_tctl) timer_en_q <= bus_wdata[0];
        end
    end

    rtc_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .stopped (stop_q),
        .advance (advance),
        .compare (compare),
        .busy    (busy)
    );

    rtc_time_core #(.RESET_YEAR_BCD(RESET_YEAR_BCD)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .wr_en   (wr_time),
        .wr_idx  (bus_addr),
        .wr_data (bus_wdata),
        .digits  (time_digits)
    );

    rtc_alarm_unit u_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dig_wr       (wr_alarm),
        .wr_idx       (bus_addr),
        .wr_data      (bus_wdata),
        .ctl_wr       (wr_actl),
        .compare      (compare),
        .time_digits  (time_digits),
        .alarm_digits (alarm_digits),
        .alarm_en     (alarm_en),
        .alarm_flag   (alarm_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (is_ctrl) begin
            bus_rdata = {bank_q, stop_q, busy};
        end else begin
            case (bank_q)
                2'd0: bus_rdata = time_digits[bus_addr];
                2'd1: begin
                    if (bus_addr < IDX_W'(N_ALARM_DIG)) bus_rdata = alarm_digits[bus_addr];
                    else if (is_aux)                     bus_rdata = {2'b00, alarm_flag, alarm_en};
                end
                2'd2: if (is_aux) bus_rdata = {3'b000, timer_en_q};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = alarm_flag && alarm_en;
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       we,
    input logic [3:0] addr,
    input logic [3:0] wdata,
    input logic       busy,
    input logic       stop_q,
    input logic [1:0] bank_q,
    input logic       af,
    input logic [3:0] sec_ones
);
    a_r4_busy_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    a_r8_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stop_q && !busy) |=> !busy);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !busy && !we) |=> $stable(sec_ones));

    a_r10_flag_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(busy));

    a_r3_page_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'hF) |=> (bank_q == $past(wdata[3:2])));
endmodule

bind bcd_calendar_rtc rtc_cal_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .busy     (busy),
    .stop_q   (stop_q),
    .bank_q   (bank_q),
    .af       (alarm_flag),
    .sec_ones (time_digits[0])
);

// File: tb/bcd_calendar_rtc_bench.sv
module bcd_calendar_rtc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic stop_v = 1'b0;
    int ms, mmi, mh, mdw, md, mmo, my;

    always #5 clk = ~clk;

    bcd_calendar_rtc u_bcd_calendar_rtc (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic sel_page(input logic [1:0] b);
        wr(4'hF, {b, stop_v, 1'b0});
    endtask

    task automatic set_stop(input logic s, input logic [1:0] b);
        stop_v = s;
        wr(4'hF, {b, s, 1'b0});
    endtask

    function automatic int days_in(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [59:0] pack_model();
        logic [59:0] e;
        e[3:0]   = 4'(ms % 10);        e[7:4]   = 4'(ms / 10);
        e[11:8]  = 4'(mmi % 10);       e[15:12] = 4'(mmi / 10);
        e[19:16] = 4'(mh % 10);        e[23:20] = 4'(mh / 10);
        e[27:24] = 4'(mdw);
        e[31:28] = 4'(md % 10);        e[35:32] = 4'(md / 10);
        e[39:36] = 4'(mmo % 10);       e[43:40] = 4'(mmo / 10);
        e[47:44] = 4'(my % 10);        e[51:48] = 4'((my / 10) % 10);
        e[55:52] = 4'((my / 100) % 10); e[59:56] = 4'(my / 1000);
        return e;
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin ms = 0; mmi++; end
        if (mmi == 60) begin mmi = 0; mh++; end
        if (mh == 24) begin
            mh = 0;
            mdw = (mdw + 1) % 7;
            md++;
            if (md > days_in(mmo, my)) begin
                md = 1; mmo++;
                if (mmo == 13) begin mmo = 1; my = (my + 1) % 10000; end
            end
        end
    endtask

    task automatic load_time(input int y, input int mo, input int d, input int dw,
                             input int h, input int mi, input int s);
        logic [59:0] p;
        my = y; mmo = mo; md = d; mdw = dw; mh = h; mmi = mi; ms = s;
        p = pack_model();
        set_stop(1'b1, 2'd0);
        for (int i = 0; i < 15; i++) wr(4'(i), p[i*4 +: 4]);
        set_stop(1'b0, 2'd0);
    endtask

    task automatic check_time(input string req);
        logic [59:0] act;
        logic [3:0]  v;
        for (int i = 0; i < 15; i++) begin
            rd(4'(i), v);
            act[i*4 +: 4] = v;
        end
        chk(req, {4'h0, act}, {4'h0, pack_model()});
    endtask

    task automatic do_tick(input logic counts);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (3) @(negedge clk);
        if (counts) model_step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] v, b1, b2, b3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; R2 digit order via model packing
        my = 2000; mmo = 1; md = 1; mdw = 0; mh = 0; mmi = 0; ms = 0;
        check_time("R1 R2 reset time");
        rd(4'hF, v); chk("R1 control", v, 4'h0);
        chk("R1 irq", irq, 1'b0);
        sel_page(2'd1); rd(4'hE, v); chk("R1 alarm ctl", v, 4'h0); sel_page(2'd0);

        // R4 busy lasts two cycles then time advanced
        @(negedge clk); tick_1hz = 1'b1; bus_addr = 4'hF;
        @(negedge clk); tick_1hz = 1'b0; #1 b1 = bus_rdata;
        @(negedge clk); #1 b2 = bus_rdata;
        @(negedge clk); #1 b3 = bus_rdata;
        chk("R4 busy cycle1", b1[0], 1'b1);
        chk("R4 busy cycle2", b2[0], 1'b1);
        chk("R4 busy done", b3[0], 1'b0);
        model_step();
        check_time("R4 advanced");

        // R5 R6 R7 continuous run across every boundary
        load_time(2023, 12, 31, 6, 23, 58, 30);
        check_time("R2 load readback");
        for (int k = 0; k < 100; k++) begin
            do_tick(1'b1);
            check_time("R5 R6 R7 running sweep");
        end

        // R7 month-end sweep, leap and common years
        for (int yy = 2023; yy <= 2024; yy++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load_time(yy, mo, days_in(mo, yy), 3, 23, 59, 59);
                do_tick(1'b1);
                check_time("R7 month end");
            end
            load_time(yy, 2, 28, 1, 23, 59, 59);
            do_tick(1'b1);
            check_time("R7 february 28");
        end
        load_time(9999, 12, 31, 5, 23, 59, 59);
        do_tick(1'b1);
        check_time("R7 year wrap");

        // R8 stop freezes, ticks dropped
        load_time(2024, 6, 10, 1, 10, 20, 30);
        set_stop(1'b1, 2'd0);
        for (int k = 0; k < 3; k++) do_tick(1'b0);
        check_time("R8 frozen while stopped");
        set_stop(1'b0, 2'd0);
        repeat (3) @(negedge clk);
        check_time("R8 no late count");
        do_tick(1'b1);
        check_time("R8 resumed");

        // R3 control on every page
        sel_page(2'd2); rd(4'hF, v); chk("R3 page2 ctl", v, 4'h8);
        sel_page(2'd3); rd(4'hF, v); chk("R3 page3 ctl", v, 4'hC);
        set_stop(1'b1, 2'd1); rd(4'hF, v); chk("R3 page1 stop ctl", v, 4'h6);
        set_stop(1'b0, 2'd1);

        // R12 unmapped and timer control
        sel_page(2'd3); wr(4'h0, 4'h9); rd(4'h0, v); chk("R12 page3 read", v, 4'h0);
        sel_page(2'd2); rd(4'h0, v); chk("R12 page2 idx0", v, 4'h0);
        wr(4'hE, 4'h3); rd(4'hE, v); chk("R12 timer ctl", v, 4'h1);
        sel_page(2'd1); wr(4'h9, 4'h7); rd(4'h9, v); chk("R12 page1 idx9", v, 4'h0);
        sel_page(2'd0); check_time("R12 time untouched");

        // R9 R10 R11 alarm with wildcard tens digits
        load_time(2024, 3, 15, 5, 12, 34, 50);
        sel_page(2'd1);
        wr(4'h0, 4'h5); wr(4'h1, 4'h5); wr(4'h2, 4'h4); wr(4'h3, 4'h8);
        wr(4'h4, 4'h2); wr(4'h5, 4'h8); wr(4'h6, 4'h8); wr(4'h7, 4'h5); wr(4'h8, 4'h8);
        wr(4'hE, 4'h1);
        rd(4'h3, v); chk("R9 ignore bit readback", v, 4'h8);
        for (int k = 0; k < 4; k++) begin
            do_tick(1'b1);
            rd(4'hE, v); chk("R10 no early flag", v, 4'h1);
            chk("R11 irq low", irq, 1'b0);
        end
        do_tick(1'b1);
        rd(4'hE, v); chk("R10 flag on match", v, 4'h3);
        chk("R11 irq high", irq, 1'b1);
        wr(4'hE, 4'h2); rd(4'hE, v); chk("R10 write one keeps flag", v, 4'h2);
        chk("R11 irq gated by enable", irq, 1'b0);
        wr(4'hE, 4'h0); rd(4'hE, v); chk("R10 write zero clears", v, 4'h0);

        // R9 exact digit blocks a match, wildcard releases it
        wr(4'hE, 4'h1);
        wr(4'h0, 4'h6); wr(4'h8, 4'h2);
        do_tick(1'b1);
        rd(4'hE, v); chk("R9 exact day tens blocks", v, 4'h1);
        chk("R11 irq stays low", irq, 1'b0);
        wr(4'h0, 4'h7); wr(4'h8, 4'h8);
        do_tick(1'b1);
        rd(4'hE, v); chk("R9 wildcard day tens matches", v, 4'h3);
        chk("R11 irq after match", irq, 1'b1);
        sel_page(2'd0);
        check_time("R4 time after alarm ticks");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule